// File: doc/BRIEF.md
# Flash Erase Command Sequence Decoder

This block watches the write strobes of a byte-wide flash-style host bus and recognises the two erase command strings. A valid string is six writes long. Every write carries an address and a data byte. Write enable and chip enable are brought into the system clock domain by a synchroniser. The address of a write is sampled when write enable falls, and its data is sampled when write enable rises.

Both strings share a five-write prefix: unlock A, unlock B, setup, unlock A, unlock B. The sixth write decides the outcome. One code starts a whole-chip erase. The other code starts an erase of the sector selected by that write's address. After either one, the decoder reports busy and ignores further command strings. The two ways out of busy are a reset write or a completion indication from the erase engine. Any write that breaks the expected order throws away the partial string, and the decoder goes back to read mode.

The erase engine, the sector-gathering time window and program commands live outside this block.

Top module: `erase_cmd_decoder`

## Requirements
- R1: After reset, `erase_busy`, `chip_erase_go`, `sector_erase_go` and `erase_abort` are all low.
- R2: These six writes produce exactly one `chip_erase_go` pulse, and `erase_busy` then goes high: 555h/AAh, 2AAh/55h, 555h/80h, 555h/AAh, 2AAh/55h, 555h/10h. Each pair is the low command address, then the data.
- R3: The same five-write prefix followed by a write of data 30h produces exactly one `sector_erase_go` pulse. `erase_sector` then equals address bits [ADDR_W-1:ADDR_W-SECT_W] of that sixth write, and `erase_busy` goes high.
- R4: A write's address is the value on `bus_addr` when write enable falls. Its data is the value on `bus_data` when write enable rises. Changes to either bus while write enable is low have no other effect.
- R5: Any address inside a sector selects that sector. The low ADDR_W-SECT_W address bits of the sector write are ignored.
- R6: A write that does not match the next expected step of a string yields no pulse and returns the decoder to read mode. A complete string written afterwards is accepted normally.
- R7: A write strobe given while `bus_ce_n` is high is ignored and does not disturb a string in progress.
- R8: While `erase_busy` is high, writes other than data F0h cause no pulse and leave `erase_busy` high. This holds even for a complete erase string.
- R9: While busy, a write of data F0h at any address gives one `erase_abort` pulse and clears `erase_busy`.
- R10: An `erase_done` pulse while busy clears `erase_busy` without any pulse.
- R11: Every go or abort output is a single-cycle pulse, and at most one of them is high in any cycle.
- R12: Unlock and setup addresses are compared on the low CMD_AW (11) address bits only. Higher address bits do not matter in those writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ce_n | input | 1 | Host chip enable, active low |
| bus_we_n | input | 1 | Host write enable, active low |
| bus_addr | input | ADDR_W | Host address |
| bus_data | input | 8 | Host write data |
| erase_done | input | 1 | Pulse from the erase engine when an erase finishes |
| chip_erase_go | output | 1 | One-cycle start of a whole-chip erase |
| sector_erase_go | output | 1 | One-cycle start of a sector erase |
| erase_abort | output | 1 | One-cycle pulse on a reset write while busy |
| erase_busy | output | 1 | An erase has been started and not yet finished or aborted |
| erase_sector | output | SECT_W | Sector index latched from the sector-erase write |

## Verification
The assertions assume that `bus_addr`, `bus_data` and `bus_ce_n` are stable for the synchroniser's delay on each side of the write-enable edge they belong to. They also assume that `erase_done` is raised only for an erase the decoder started. The bench sets chip enable, address and data several clocks before lowering write enable. It keeps them stable for five clocks after each write-enable edge. The one exception is the R4 write, which changes both buses on purpose in the middle of its low phase. The bench drives `erase_done` only while busy.

// File: rtl/erase_dec_pkg.sv
package erase_dec_pkg;

  typedef enum logic [2:0] {
    ST_READ,
    ST_GOT_A1,
    ST_GOT_B1,
    ST_GOT_SETUP,
    ST_GOT_A2,
    ST_GOT_B2,
    ST_BUSY
  } seq_state_e;

  localparam int unsigned CMD_AW = 11;

  localparam logic [CMD_AW-1:0] ADR_KEY_A = 11'h555;
  localparam logic [CMD_AW-1:0] ADR_KEY_B = 11'h2AA;

  localparam logic [7:0] DAT_KEY_A   = 8'hAA;
  localparam logic [7:0] DAT_KEY_B   = 8'h55;
  localparam logic [7:0] DAT_SETUP   = 8'h80;
  localparam logic [7:0] DAT_CHIP    = 8'h10;
  localparam logic [7:0] DAT_SECTOR  = 8'h30;
  localparam logic [7:0] DAT_RESET   = 8'hF0;

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic we_n,
  output logic fall_p,
  output logic rise_p
);

  localparam int unsigned WE_LEN = STAGES + 1;

  logic [WE_LEN-1:0] we_sh_q;
  logic [STAGES-1:0] ce_sh_q;
  logic [WE_LEN-1:0] we_sh_d;
  logic [STAGES-1:0] ce_sh_d;

  genvar g;
  generate
    for (g = 0; g < WE_LEN; g++) begin : g_we_chain
      if (g == 0) begin : g_head
        assign we_sh_d[g] = we_n;
      end else begin : g_tail
        assign we_sh_d[g] = we_sh_q[g-1];
      end
    end
    for (g = 0; g < STAGES; g++) begin : g_ce_chain
      if (g == 0) begin : g_head
        assign ce_sh_d[g] = ce_n;
      end else begin : g_tail
        assign ce_sh_d[g] = ce_sh_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_sh_q <= '1;
      ce_sh_q <= '1;
    end else begin
      we_sh_q <= we_sh_d;
      ce_sh_q <= ce_sh_d;
    end
  end

  always_comb begin
    fall_p = we_sh_q[WE_LEN-1] & ~we_sh_q[STAGES-1] & ~ce_sh_q[STAGES-1];
    rise_p = ~we_sh_q[WE_LEN-1] & we_sh_q[STAGES-1];
  end

endmodule

// File: rtl/bus_capture.sv
module bus_capture #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall_p,
  input  logic              rise_p,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_data,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);

  logic              armed_q, armed_d;
  logic              valid_q, valid_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [7:0]        data_q, data_d;

  always_comb begin
    armed_d = armed_q;
    valid_d = 1'b0;
    addr_d  = addr_q;
    data_d  = data_q;
    if (fall_p) begin
      armed_d = 1'b1;
      addr_d  = bus_addr;
    end else if (rise_p && armed_q) begin
      armed_d = 1'b0;
      data_d  = bus_data;
      valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      valid_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      armed_q <= armed_d;
      valid_q <= valid_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
    end
  end

  assign wr_valid = valid_q;
  assign wr_addr  = addr_q;
  assign wr_data  = data_q;

endmodule

// File: rtl/erase_seq_fsm.sv
module erase_seq_fsm
  import erase_dec_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned SECT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              erase_done,
  output logic              chip_go,
  output logic              sector_go,
  output logic              abort_go,
  output logic              busy,
  output logic [SECT_W-1:0] sector_id
);

  localparam int unsigned SECT_LSB = ADDR_W - SECT_W;

  seq_state_e        state_q, state_d;
  logic              chip_q, chip_d;
  logic              sect_q, sect_d;
  logic              abort_q, abort_d;
  logic [SECT_W-1:0] sid_q, sid_d;

  logic [CMD_AW-1:0] cmd_adr;
  logic              hit_a, hit_b, hit_setup, hit_chip, hit_sect, hit_reset;

  always_comb begin
    cmd_adr   = wr_addr[CMD_AW-1:0];
    hit_a     = (cmd_adr == ADR_KEY_A) && (wr_data == DAT_KEY_A);
    hit_b     = (cmd_adr == ADR_KEY_B) && (wr_data == DAT_KEY_B);
    hit_setup = (cmd_adr == ADR_KEY_A) && (wr_data == DAT_SETUP);
    hit_chip  = (cmd_adr == ADR_KEY_A) && (wr_data == DAT_CHIP);
    hit_sect  = (wr_data == DAT_SECTOR);
    hit_reset = (wr_data == DAT_RESET);
  end

  always_comb begin
    state_d = state_q;
    chip_d  = 1'b0;
    sect_d  = 1'b0;
    abort_d = 1'b0;
    sid_d   = sid_q;
    unique case (state_q)
      ST_READ:      if (wr_valid) state_d = hit_a     ? ST_GOT_A1    : ST_READ;
      ST_GOT_A1:    if (wr_valid) state_d = hit_b     ? ST_GOT_B1    : ST_READ;
      ST_GOT_B1:    if (wr_valid) state_d = hit_setup ? ST_GOT_SETUP : ST_READ;
      ST_GOT_SETUP: if (wr_valid) state_d = hit_a     ? ST_GOT_A2    : ST_READ;
      ST_GOT_A2:    if (wr_valid) state_d = hit_b     ? ST_GOT_B2    : ST_READ;
      ST_GOT_B2: begin
        if (wr_valid) begin
          if (hit_chip) begin
            state_d = ST_BUSY;
            chip_d  = 1'b1;
          end else if (hit_sect) begin
            state_d = ST_BUSY;
            sect_d  = 1'b1;
            sid_d   = wr_addr[ADDR_W-1:SECT_LSB];
          end else begin
            state_d = ST_READ;
          end
        end
      end
      ST_BUSY: begin
        if (wr_valid && hit_reset) begin
          state_d = ST_READ;
          abort_d = 1'b1;
        end else if (erase_done) begin
          state_d = ST_READ;
        end
      end
      default: state_d = ST_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_READ;
      chip_q  <= 1'b0;
      sect_q  <= 1'b0;
      abort_q <= 1'b0;
      sid_q   <= '0;
    end else begin
      state_q <= state_d;
      chip_q  <= chip_d;
      sect_q  <= sect_d;
      abort_q <= abort_d;
      sid_q   <= sid_d;
    end
  end

  assign chip_go   = chip_q;
  assign sector_go = sect_q;
  assign abort_go  = abort_q;
  assign busy      = (state_q == ST_BUSY);
  assign sector_id = sid_q;

endmodule

// File: rtl/erase_cmd_decoder.sv
module erase_cmd_decoder #(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned SECT_W      = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_ce_n,
  input  logic              bus_we_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_data,
  input  logic              erase_done,
  output logic              chip_erase_go,
  output logic              sector_erase_go,
  output logic              erase_abort,
  output logic              erase_busy,
  output logic [SECT_W-1:0] erase_sector
);

  logic [1:0]        rst_sh_q;
  logic              rst_int_n;
  logic              fall_p, rise_p;
  logic              wr_valid;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= 2'b00;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_int_n = rst_sh_q[1];

  strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .ce_n   (bus_ce_n),
    .we_n   (bus_we_n),
    .fall_p (fall_p),
    .rise_p (rise_p)
  );

  bus_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .fall_p   (fall_p),
    .rise_p   (rise_p),
    .bus_addr (bus_addr),
    .bus_data (bus_data),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );

  erase_seq_fsm #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .wr_valid   (wr_valid),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .erase_done (erase_done),
    .chip_go    (chip_erase_go),
    .sector_go  (sector_erase_go),
    .abort_go   (erase_abort),
    .busy       (erase_busy),
    .sector_id  (erase_sector)
  );

endmodule

// File: rtl/erase_cmd_decoder_chk.sv
module erase_cmd_decoder_chk #(
  parameter int unsigned SECT_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chip_go,
  input logic              sector_go,
  input logic              abort_go,
  input logic              busy,
  input logic [SECT_W-1:0] sector_id
);

  a_r11_one_pulse_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({chip_go, sector_go, abort_go}));

  a_r11_chip_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    chip_go |=> !chip_go);

  a_r11_sector_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    sector_go |=> !sector_go);

  a_r2_busy_rise_needs_go: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (chip_go || sector_go));

  a_r3_go_enters_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_go || sector_go) |-> busy);

  a_r8_no_go_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_go || sector_go) |-> !$past(busy));

  a_r9_abort_leaves_busy: assert property (@(posedge clk) disable iff (!rst_n)
    abort_go |-> ($past(busy) && !busy));

  a_r3_sector_held_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(sector_id));

endmodule

bind erase_cmd_decoder erase_cmd_decoder_chk #(.SECT_W(SECT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .chip_go   (chip_erase_go),
  .sector_go (sector_erase_go),
  .abort_go  (erase_abort),
  .busy      (erase_busy),
  .sector_id (erase_sector)
);

// File: tb/erase_cmd_decoder_test.sv
`timescale 1ns/1ps
module erase_cmd_decoder_test;

  localparam int unsigned ADDR_W = 16;
  localparam int unsigned SECT_W = 5;

  typedef struct packed {
    logic [1:0]        kind;   // 1 chip, 2 sector, 3 abort
    logic [SECT_W-1:0] sect;
  } exp_item_t;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              bus_ce_n, bus_we_n;
  logic [ADDR_W-1:0] bus_addr;
  logic [7:0]        bus_data;
  logic              erase_done;
  logic              chip_erase_go, sector_erase_go, erase_abort, erase_busy;
  logic [SECT_W-1:0] erase_sector;

  exp_item_t exp_q[$];
  int n_vec  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  erase_cmd_decoder #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) uut (
    .clk(clk), .rst_n(rst_n), .bus_ce_n(bus_ce_n), .bus_we_n(bus_we_n),
    .bus_addr(bus_addr), .bus_data(bus_data), .erase_done(erase_done),
    .chip_erase_go(chip_erase_go), .sector_erase_go(sector_erase_go),
    .erase_abort(erase_abort), .erase_busy(erase_busy), .erase_sector(erase_sector)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic expect_item(input logic [1:0] kind, input logic [SECT_W-1:0] sect);
    exp_item_t it;
    it.kind = kind;
    it.sect = sect;
    exp_q.push_back(it);
  endtask

  // monitor: pops expected pulses and compares
  always @(negedge clk) begin
    if (rst_n && (chip_erase_go || sector_erase_go || erase_abort)) begin
      logic [1:0] k;
      k = chip_erase_go ? 2'd1 : (sector_erase_go ? 2'd2 : 2'd3);
      if (exp_q.size() == 0) begin
        check(1'b0, "R6/R8/R11 unexpected pulse", int'(k), 0);
      end else begin
        exp_item_t it;
        it = exp_q.pop_front();
        check(k == it.kind, "R2/R3/R9 pulse kind", int'(k), int'(it.kind));
        if (it.kind == 2'd2)
          check(erase_sector == it.sect, "R3/R5 sector", int'(erase_sector), int'(it.sect));
      end
    end
  end

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [7:0] d, input bit ce = 1'b1);
    @(negedge clk);
    bus_ce_n = ~ce; bus_addr = a; bus_data = d;
    repeat (3) @(negedge clk);
    bus_we_n = 1'b0;
    repeat (5) @(negedge clk);
    bus_we_n = 1'b1;
    repeat (5) @(negedge clk);
    bus_ce_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic split_write(input logic [ADDR_W-1:0] a1, input logic [7:0] d1,
                             input logic [ADDR_W-1:0] a2, input logic [7:0] d2);
    @(negedge clk);
    bus_ce_n = 1'b0; bus_addr = a1; bus_data = d1;
    repeat (3) @(negedge clk);
    bus_we_n = 1'b0;
    repeat (5) @(negedge clk);
    bus_addr = a2; bus_data = d2;
    repeat (3) @(negedge clk);
    bus_we_n = 1'b1;
    repeat (5) @(negedge clk);
    bus_ce_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic prefix();
    bus_write(16'h0555, 8'hAA);
    bus_write(16'h02AA, 8'h55);
    bus_write(16'h0555, 8'h80);
    bus_write(16'h0555, 8'hAA);
    bus_write(16'h02AA, 8'h55);
  endtask

  task automatic settle(input string req);
    repeat (8) @(negedge clk);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  task automatic finish_erase();
    @(negedge clk); erase_done = 1'b1;
    @(negedge clk); erase_done = 1'b0;
    repeat (2) @(negedge clk);
    check(erase_busy == 1'b0, "R10 busy cleared by done", erase_busy, 0);
  endtask

  initial begin
    #(4ns * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_ce_n = 1'b1; bus_we_n = 1'b1;
    bus_addr = '0; bus_data = '0; erase_done = 1'b0;
    repeat (4) @(negedge clk);
    check({erase_busy, chip_erase_go, sector_erase_go, erase_abort} == 4'b0, "R1 reset outputs",
          {erase_busy, chip_erase_go, sector_erase_go, erase_abort}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(erase_busy == 1'b0, "R1 idle after reset", erase_busy, 0);

    // R2 chip erase
    prefix();
    expect_item(2'd1, '0);
    bus_write(16'h0555, 8'h10);
    settle("R2 chip pulse seen");
    check(erase_busy == 1'b1, "R2 busy after chip", erase_busy, 1);

    // R8 full string while busy is ignored
    prefix();
    bus_write(16'h0555, 8'h10);
    settle("R8 no pulse while busy");
    check(erase_busy == 1'b1, "R8 still busy", erase_busy, 1);

    // R9 reset write
    expect_item(2'd3, '0);
    bus_write(16'h1234, 8'hF0);
    settle("R9 abort pulse seen");
    check(erase_busy == 1'b0, "R9 busy cleared by reset", erase_busy, 0);

    // R3 sector erase
    prefix();
    expect_item(2'd2, 5'h0A);
    bus_write(16'h5234, 8'h30);
    settle("R3 sector pulse seen");
    check(erase_busy == 1'b1, "R3 busy after sector", erase_busy, 1);
    finish_erase();

    // R5 other addresses inside sectors
    prefix();
    expect_item(2'd2, 5'h0A);
    bus_write(16'h57FF, 8'h30);
    settle("R5 same sector from other offset");
    finish_erase();
    prefix();
    expect_item(2'd2, 5'h15);
    bus_write(16'hA800, 8'h30);
    settle("R5 sector 15h");
    finish_erase();

    // R6 break in the middle, then a good string
    bus_write(16'h0555, 8'hAA);
    bus_write(16'h02AA, 8'h55);
    bus_write(16'h0555, 8'h81);
    bus_write(16'h0555, 8'hAA);
    bus_write(16'h02AA, 8'h55);
    bus_write(16'h0555, 8'h10);
    settle("R6 broken string gives no pulse");
    check(erase_busy == 1'b0, "R6 read mode after break", erase_busy, 0);
    prefix();
    bus_write(16'h0555, 8'h20);
    settle("R6 bad final command no pulse");
    check(erase_busy == 1'b0, "R6 read mode after bad final", erase_busy, 0);
    prefix();
    expect_item(2'd1, '0);
    bus_write(16'h0555, 8'h10);
    settle("R6 good string after break");
    finish_erase();

    // R7 strobe with chip enable high inside a string
    bus_write(16'h0555, 8'hAA);
    bus_write(16'h0555, 8'h00, 1'b0);
    bus_write(16'h02AA, 8'h55);
    bus_write(16'h0555, 8'h80);
    bus_write(16'h0555, 8'hAA);
    bus_write(16'h0100, 8'h33, 1'b0);
    bus_write(16'h02AA, 8'h55);
    expect_item(2'd1, '0);
    bus_write(16'h0555, 8'h10);
    settle("R7 disabled strobes ignored");
    finish_erase();

    // R12 high address bits ignored in unlock writes
    bus_write(16'hF555, 8'hAA);
    bus_write(16'hFAAA, 8'h55);
    bus_write(16'h8555, 8'h80);
    bus_write(16'h3555, 8'hAA);
    bus_write(16'h7AAA, 8'h55);
    expect_item(2'd1, '0);
    bus_write(16'hC555, 8'h10);
    settle("R12 upper bits ignored");
    finish_erase();

    // R4 address at falling edge, data at rising edge
    prefix();
    expect_item(2'd2, 5'h03);
    split_write(16'h1800, 8'h00, 16'hE000, 8'h30);
    settle("R4 edge capture");
    check(erase_busy == 1'b1, "R4 busy", erase_busy, 1);
    finish_erase();

    // R9 reset write while idle does nothing
    bus_write(16'h0000, 8'hF0);
    settle("R9 idle reset write no pulse");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule